// File: doc/BRIEF.md
# Floppy controller wait-state READY generator

This block drives the READY line that a floppy controller card presents to the host CPU. When software has armed the wait trap and the CPU touches the controller's data-register slot before the controller has a byte to hand over, READY drops and the CPU is held in wait states. READY comes back as soon as the controller raises its data request, raises its completion interrupt, or the drive motor stops. In every other case READY stays high and accesses run at full speed.

The block also contains the motor-on timer. A rising edge on a software-driven motor bit starts the timer, and each new rising edge restarts it. While the timer runs, the controller's force-ready input is held high and every drive's active-low motor enable is driven low, all together. The timer also supplies the motor term of the stall condition.

Two board variants are chosen by a parameter. Variant A decodes the slot as one three-bit match. Variant B first forms a trap term from the enable, the upper two of the three address bits and the motor, then adds the even-byte check. Both stall on the same address pattern. READY is combinational from the latched address, the window strobe and the registered state, so it reacts in the same cycle as the address.

Top module: `fdc_wait_ready`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), `ready_o` is 1, `force_ready_o` is 0 and every bit of `motor_en_n_o` is 1. The trap enable is cleared and the motor timer is stopped.
- R2: `ready_o` is 0 only when all of these hold: `win_i` is 1, `addr_low_i` equals 3'b110, the trap enable is 1, `drq_i` is 0, `intrq_i` is 0 and the motor timer is running.
- R3: If any single condition of R2 is false (for example `win_i` is 0, or `addr_low_i` is 3'b111, 3'b100 or 3'b010), `ready_o` is 1.
- R4: With BOARD set to BOARD_B (1), the stall uses a trap term: trap enable AND `addr_low_i[2]` AND `addr_low_i[1]` AND motor running. The stall also needs `addr_low_i[0]` equal to 0, `win_i`, and low `drq_i` and `intrq_i`. It gives the same result as R2 for every input.
- R5: `drq_i` or `intrq_i` at 1 sets `ready_o` to 1 in the same cycle, with no clock edge in between.
- R6: A clock edge where `motor_bit_i` is 1 and was 0 at the previous edge starts the motor timer. The timer then runs for exactly MOTOR_CYCLES clock cycles.
- R7: A new rising edge of `motor_bit_i` while the timer runs reloads the timer to the full MOTOR_CYCLES.
- R8: Keeping `motor_bit_i` at 1 does not reload the timer. The timer stops MOTOR_CYCLES cycles after the edge that started it.
- R9: While the timer runs, `force_ready_o` is 1 and all DRIVES bits of `motor_en_n_o` are 0. Otherwise `force_ready_o` is 0 and all bits are 1.
- R10: A clock edge with `trap_we_i` at 1 loads `trap_wd_i` into the trap enable. A change of address or strobe affects `ready_o` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_low_i | input | 3 | Low three bits of the latched bus address |
| win_i | input | 1 | Controller register window is addressed |
| trap_we_i | input | 1 | Write strobe for the trap enable |
| trap_wd_i | input | 1 | Value written into the trap enable |
| motor_bit_i | input | 1 | Software motor bit; a rising edge triggers the timer |
| drq_i | input | 1 | Controller data request |
| intrq_i | input | 1 | Controller completion interrupt |
| ready_o | output | 1 | Host READY; 0 inserts wait states |
| force_ready_o | output | 1 | Force-ready input of the controller |
| motor_en_n_o | output | DRIVES | Drive motor enables, active low |

## Verification
The assertions assume that the inputs hold known values from reset onward. They also assume that the address bits and window strobe are already latched upstream, so that a change in them between edges is a real bus change and not a glitch. The stimulus changes inputs only just after a rising edge and keeps them steady until the next one. The motor timer is started again before each group of stall checks, so that the running motor is a known condition. The stall patterns are applied at the same time to one instance of each board variant.

// File: rtl/fdc_wait_pkg.sv
package fdc_wait_pkg;

    typedef enum logic {
        BOARD_A = 1'b0,
        BOARD_B = 1'b1
    } board_e;

    typedef struct packed {
        logic trap;
    } trap_state_t;

endpackage

// File: rtl/motor_timer.sv
module motor_timer #(
    parameter int unsigned CYCLES = 150_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic motor_bit_i,
    output logic run_o
);
    localparam int unsigned CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);

    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic       start;

    always_comb begin
        st_d      = st_q;
        start     = motor_bit_i && !st_q.prev;
        st_d.prev = motor_bit_i;
        if (start) begin
            st_d.cnt = LOAD;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o = (st_q.cnt != '0);

    // R6, R7
    restart_load_chk: assert property (@(posedge clk) disable iff (rst)
        (motor_bit_i && !st_q.prev) |=> (st_q.cnt == LOAD));

    // R8
    steady_decay_chk: assert property (@(posedge clk) disable iff (rst)
        (run_o && !(motor_bit_i && !st_q.prev)) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

endmodule

// File: rtl/stall_decode.sv
module stall_decode
    import fdc_wait_pkg::*;
#(
    parameter board_e BOARD = BOARD_A
) (
    input  logic [2:0] addr_low_i,
    input  logic       win_i,
    input  logic       trap_i,
    input  logic       drq_i,
    input  logic       intrq_i,
    input  logic       motor_i,
    output logic       stall_o
);
    logic idle_ctl;

    assign idle_ctl = !drq_i && !intrq_i;

    generate
        if (BOARD == BOARD_A) begin : g_board_a
            logic slot_hit;
            assign slot_hit = (addr_low_i == 3'b110);
            assign stall_o  = win_i && slot_hit && trap_i && idle_ctl && motor_i;
        end else begin : g_board_b
            logic trap_term;
            logic even_byte;
            assign trap_term = trap_i && addr_low_i[2] && addr_low_i[1] && motor_i;
            assign even_byte = !addr_low_i[0];
            assign stall_o   = win_i && even_byte && trap_term && idle_ctl;
        end
    endgenerate

endmodule

// File: rtl/fdc_wait_ready.sv
module fdc_wait_ready
    import fdc_wait_pkg::*;
#(
    parameter board_e      BOARD        = BOARD_A,
    parameter int unsigned DRIVES       = 4,
    parameter int unsigned MOTOR_CYCLES = 150_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        addr_low_i,
    input  logic              win_i,
    input  logic              trap_we_i,
    input  logic              trap_wd_i,
    input  logic              motor_bit_i,
    input  logic              drq_i,
    input  logic              intrq_i,
    output logic              ready_o,
    output logic              force_ready_o,
    output logic [DRIVES-1:0] motor_en_n_o
);
    trap_state_t tr_d, tr_q;
    logic        motor_run;
    logic        stall;

    always_comb begin
        tr_d = tr_q;
        if (trap_we_i) begin
            tr_d.trap = trap_wd_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tr_q <= '0;
        end else begin
            tr_q <= tr_d;
        end
    end

    motor_timer #(
        .CYCLES (MOTOR_CYCLES)
    ) u_motor_timer (
        .clk         (clk),
        .rst         (rst),
        .motor_bit_i (motor_bit_i),
        .run_o       (motor_run)
    );

    stall_decode #(
        .BOARD (BOARD)
    ) u_stall_decode (
        .addr_low_i (addr_low_i),
        .win_i      (win_i),
        .trap_i     (tr_q.trap),
        .drq_i      (drq_i),
        .intrq_i    (intrq_i),
        .motor_i    (motor_run),
        .stall_o    (stall)
    );

    assign ready_o       = !stall;
    assign force_ready_o = motor_run;
    assign motor_en_n_o  = {DRIVES{!motor_run}};

    // R5
    ctl_release_chk: assert property (@(posedge clk) disable iff (rst)
        (drq_i || intrq_i) |-> ready_o);

    // R2
    stall_cond_chk: assert property (@(posedge clk) disable iff (rst)
        !ready_o |-> (win_i && tr_q.trap && motor_run && addr_low_i[2] && addr_low_i[1] && !addr_low_i[0]));

    // R2
    motor_off_runs_chk: assert property (@(posedge clk) disable iff (rst)
        !force_ready_o |-> ready_o);

    // R10
    trap_load_chk: assert property (@(posedge clk) disable iff (rst)
        trap_we_i |=> (tr_q.trap == $past(trap_wd_i)));

endmodule

// File: tb/test_fdc_wait_ready.sv
module test_fdc_wait_ready;
    import fdc_wait_pkg::*;

    localparam int unsigned N = 20;

    typedef struct {
        logic       rdy;
        logic       frc;
        logic [3:0] en_n;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr = 3'b000;
    logic       win = 1'b0, twe = 1'b0, twd = 1'b0, mbit = 1'b0, drq = 1'b0, irq = 1'b0;
    logic       rdy_a, frc_a, rdy_b, frc_b;
    logic [3:0] en_a, en_b;

    int   vectors = 0;
    int   miscompares = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;

    fdc_wait_ready #(.BOARD(BOARD_A), .DRIVES(4), .MOTOR_CYCLES(N)) i_fdc_wait_ready (
        .clk(clk), .rst(rst), .addr_low_i(addr), .win_i(win), .trap_we_i(twe), .trap_wd_i(twd),
        .motor_bit_i(mbit), .drq_i(drq), .intrq_i(irq),
        .ready_o(rdy_a), .force_ready_o(frc_a), .motor_en_n_o(en_a));

    fdc_wait_ready #(.BOARD(BOARD_B), .DRIVES(4), .MOTOR_CYCLES(N)) i_fdc_wait_ready_b (
        .clk(clk), .rst(rst), .addr_low_i(addr), .win_i(win), .trap_we_i(twe), .trap_wd_i(twd),
        .motor_bit_i(mbit), .drq_i(drq), .intrq_i(irq),
        .ready_o(rdy_b), .force_ready_o(frc_b), .motor_en_n_o(en_b));

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_now(string tag, logic r, logic f);
        exp_t e;
        e.rdy  = r;
        e.frc  = f;
        e.en_n = f ? 4'b0000 : 4'b1111;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    task automatic bus(logic w, logic [2:0] a, logic d, logic i);
        win  = w;
        addr = a;
        drq  = d;
        irq  = i;
    endtask

    task automatic kick();
        mbit = 1'b0;
        step();
        mbit = 1'b1;
        step();
    endtask

    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            vectors++;
            if (rdy_a !== e.rdy || frc_a !== e.frc || en_a !== e.en_n) begin
                miscompares++;
                $display("FAIL %s board A: actual ready=%b force=%b en_n=%b expected ready=%b force=%b en_n=%b",
                         e.tag, rdy_a, frc_a, en_a, e.rdy, e.frc, e.en_n);
            end
            if (rdy_b !== e.rdy || frc_b !== e.frc || en_b !== e.en_n) begin
                miscompares++;
                $display("FAIL %s board B: actual ready=%b force=%b en_n=%b expected ready=%b force=%b en_n=%b",
                         e.tag, rdy_b, frc_b, en_b, e.rdy, e.frc, e.en_n);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        // R1 reset state, stall pattern present but trap and motor off
        bus(1'b1, 3'b110, 1'b0, 1'b0);
        expect_now("R1 reset", 1'b1, 1'b0);
        step();

        // R10 arm the trap
        twe = 1'b1; twd = 1'b1;
        step();
        twe = 1'b0;
        expect_now("R10 trap armed, motor off", 1'b1, 1'b0);

        // R6 R9 motor start
        kick();
        expect_now("R6 R9 motor started", 1'b0, 1'b1);
        step();
        bus(1'b1, 3'b111, 1'b0, 1'b0);
        expect_now("R3 odd byte 111", 1'b1, 1'b1);
        step();
        bus(1'b1, 3'b100, 1'b0, 1'b0);
        expect_now("R3 pattern 100", 1'b1, 1'b1);
        step();
        bus(1'b1, 3'b010, 1'b0, 1'b0);
        expect_now("R3 pattern 010", 1'b1, 1'b1);
        step();
        bus(1'b0, 3'b110, 1'b0, 1'b0);
        expect_now("R3 window off", 1'b1, 1'b1);
        step();
        bus(1'b1, 3'b110, 1'b0, 1'b0);
        expect_now("R2 R4 R10 stall same cycle", 1'b0, 1'b1);
        step();
        bus(1'b1, 3'b110, 1'b1, 1'b0);
        expect_now("R5 drq releases", 1'b1, 1'b1);
        step();
        bus(1'b1, 3'b110, 1'b0, 1'b1);
        expect_now("R5 intrq releases", 1'b1, 1'b1);
        step();
        bus(1'b1, 3'b110, 1'b1, 1'b1);
        expect_now("R5 both release", 1'b1, 1'b1);
        step();
        bus(1'b1, 3'b110, 1'b0, 1'b0);
        expect_now("R4 stall again", 1'b0, 1'b1);

        // R10 disarm the trap
        twe = 1'b1; twd = 1'b0;
        step();
        twe = 1'b0;
        expect_now("R10 trap cleared", 1'b1, 1'b1);
        twe = 1'b1; twd = 1'b1;
        step();
        twe = 1'b0;
        expect_now("R10 trap rearmed", 1'b0, 1'b1);

        // R8 steady high bit: timeout N cycles after the start edge
        kick();
        for (int k = 1; k <= N - 1; k++) begin
            step();
        end
        expect_now("R8 last running cycle", 1'b0, 1'b1);
        step();
        expect_now("R8 timer expired, R2 motor term", 1'b1, 1'b0);
        step();
        expect_now("R8 stays stopped", 1'b1, 1'b0);

        // R7 retrigger while running
        kick();
        for (int k = 0; k < 5; k++) begin
            step();
        end
        mbit = 1'b0;
        step();
        mbit = 1'b1;
        step();
        for (int k = 1; k <= N - 1; k++) begin
            step();
        end
        expect_now("R7 reloaded still running", 1'b0, 1'b1);
        step();
        expect_now("R7 reloaded expired", 1'b1, 1'b0);

        // R1 reset mid-run
        kick();
        rst = 1'b1;
        step();
        rst = 1'b0;
        expect_now("R1 reset clears timer and trap", 1'b1, 1'b0);
        kick();
        expect_now("R1 trap stays cleared after reset", 1'b1, 1'b1);
        step();
        step();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule